// File: doc/BRIEF.md
# Six-Channel Pulse-Width Modulator with Buffered Settings

This block generates six independent pulse-width waveforms. Each channel runs a free-running cycle counter. The counter rolls over at the end of each programmed period. While the counter sits below the programmed duty count, the output holds the first-phase level; for the rest of the period it holds the opposite level. Software reaches each channel through a small 32-bit register bus that has a write strobe, a read strobe, a byte address and write data. Read data returns one cycle after the read strobe.

Period and duty writes go into holding (shadow) registers. They have no effect on the waveform until software writes the channel's control register with its update bit set. On a running channel, the new settings then move into the working registers at the next counter rollover, so no period is ever cut short or stretched. On a channel that has not been started, the transfer happens at once. A separate start bit launches the counter. Once set, start stays set until reset.

Top module: `pwm_bank`

## Requirements
- R1: After reset every output is low, and the control, period and duty registers of every channel read back as zero.
- R2: Channel n's registers sit at byte base n*0x20. Within that base, control is at +0x00, period at +0x08 and duty at +0x0C. Reads of any other offset, and of any address at or above 0xB0, return zero, and writes there change nothing.
- R3: Writing period or duty without a later update request leaves the running waveform unchanged.
- R4: An update request issued on a running channel takes effect only at the next counter rollover. The period in progress keeps its old high and low lengths, and the following period uses the new values.
- R5: An update request (control bit 2) on a channel that has not been started copies the buffered values at once, so the first period after start already uses them. Bit 2 reads back as zero once the copy has been made.
- R6: With control bit 8 set, the output is high for duty cycles and then low for period minus duty cycles.
- R7: With control bit 8 clear, the output is low for the first duty cycles and high for the rest of the period.
- R8: With bit 8 set, a duty of zero gives a constant low output.
- R9: A duty greater than or equal to a nonzero period holds the output at the first-phase level for good.
- R10: A working period of zero holds a running channel at the level opposite to the first-phase level.
- R11: Writing control bit 0 as one starts the channel. Writing it as zero later does not stop the channel, and each channel runs independently of the others.
- R12: While an update request waits for the rollover, bit 2 of the control register reads back as one. It clears at the rollover. Control readback also shows bit 0 (started), bit 5 (continuous) and bit 8 (first-phase level).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the counters advance one step per cycle |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after bus_rd |
| pwm_out | output | 6 | One registered waveform output per channel |

## Verification
A wrong working register, or a commit made at the wrong moment, shows up as a wrong high or low run length on pwm_out. It appears within the period in which the fault happens. The register one stage before the output delays every such symptom by exactly one cycle. The bench therefore measures whole run lengths at the pins and does not sample single edges. A wrong pending flag is visible on the next control read. This matters most for an update made in the middle of a period: there the low run that spans the bus writes must keep its old length, and only the run after it may change.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int STRIDE_LG = 5;
  localparam int OFF_CTRL  = 5'h00;
  localparam int OFF_PER   = 5'h08;
  localparam int OFF_DUTY  = 5'h0C;
  localparam int BIT_RUN   = 0;
  localparam int BIT_UPD   = 2;
  localparam int BIT_CONT  = 5;
  localparam int BIT_LVL   = 8;
endpackage

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
  import pwm_bank_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_ctrl,
  input  logic          wr_per,
  input  logic          wr_duty,
  input  logic [DW-1:0] wdata,
  input  logic          wrap,
  output logic          run,
  output logic          pend,
  output logic          cont,
  output logic          sh_lvl,
  output logic [DW-1:0] sh_per,
  output logic [DW-1:0] sh_duty,
  output logic [DW-1:0] act_per,
  output logic [DW-1:0] act_duty,
  output logic          act_lvl
);
  logic req_upd;
  logic commit_now;
  logic arm;

  assign req_upd    = wr_ctrl && wdata[BIT_UPD];
  assign commit_now = req_upd && !run;
  assign arm        = req_upd && run;

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      pend     <= 1'b0;
      cont     <= 1'b0;
      sh_lvl   <= 1'b0;
      sh_per   <= '0;
      sh_duty  <= '0;
      act_per  <= '0;
      act_duty <= '0;
      act_lvl  <= 1'b0;
    end else begin
      if (wr_per)  sh_per  <= wdata;
      if (wr_duty) sh_duty <= wdata;
      if (wr_ctrl) begin
        cont   <= wdata[BIT_CONT];
        sh_lvl <= wdata[BIT_LVL];
        if (wdata[BIT_RUN]) run <= 1'b1;
      end
      if (commit_now) begin
        act_per  <= sh_per;
        act_duty <= sh_duty;
        act_lvl  <= wdata[BIT_LVL];
      end else if (run && wrap && pend) begin
        act_per  <= sh_per;
        act_duty <= sh_duty;
        act_lvl  <= sh_lvl;
        pend     <= 1'b0;
      end
      if (arm) pend <= 1'b1;
    end
  end

  // R5
  pend_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !run |-> !pend);

  // R3
  act_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !wrap) |=> ($stable(act_per) && $stable(act_duty) && $stable(act_lvl)));
endmodule

// File: rtl/pwm_chan_core.sv
module pwm_chan_core #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [DW-1:0] per,
  input  logic [DW-1:0] duty,
  input  logic          lvl,
  output logic          wrap,
  output logic          out
);
  logic [DW-1:0] cnt;
  logic          at_end;

  assign at_end = (per == '0) || (cnt == per - 1'b1);
  assign wrap   = run && at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      out <= 1'b0;
    end else begin
      if (run) cnt <= at_end ? '0 : cnt + 1'b1;
      if (!run)            out <= 1'b0;
      else if (per == '0)  out <= ~lvl;
      else                 out <= (cnt < duty) ? lvl : ~lvl;
    end
  end

  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> !out);

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (run && per != '0) |-> (cnt < per));

  // R9
  full_duty_chk: assert property (@(posedge clk) disable iff (rst)
    (run && per != '0 && duty >= per) |=> (out == $past(lvl)));
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int DW     = 32,
  parameter int AW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  localparam int CW    = AW - STRIDE_LG;
  localparam int SPACE = (NUM_CH - 1) * (1 << STRIDE_LG) + 16;

  logic [CW-1:0]        ch_sel;
  logic [STRIDE_LG-1:0] off;
  logic                 in_space;

  assign ch_sel   = bus_addr[AW-1:STRIDE_LG];
  assign off      = bus_addr[STRIDE_LG-1:0];
  assign in_space = int'(bus_addr) < SPACE;

  logic [DW-1:0] ctrl_rb [NUM_CH];
  logic [DW-1:0] per_rb  [NUM_CH];
  logic [DW-1:0] duty_rb [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic          hit, run, pend, cont, sh_lvl, act_lvl, wrap;
    logic [DW-1:0] act_per, act_duty;

    assign hit = bus_wr && in_space && (ch_sel == CW'(i));

    pwm_chan_regs #(.DW(DW)) u_regs (
      .clk      (clk),
      .rst      (rst),
      .wr_ctrl  (hit && off == STRIDE_LG'(OFF_CTRL)),
      .wr_per   (hit && off == STRIDE_LG'(OFF_PER)),
      .wr_duty  (hit && off == STRIDE_LG'(OFF_DUTY)),
      .wdata    (bus_wdata),
      .wrap     (wrap),
      .run      (run),
      .pend     (pend),
      .cont     (cont),
      .sh_lvl   (sh_lvl),
      .sh_per   (per_rb[i]),
      .sh_duty  (duty_rb[i]),
      .act_per  (act_per),
      .act_duty (act_duty),
      .act_lvl  (act_lvl)
    );

    pwm_chan_core #(.DW(DW)) u_core (
      .clk  (clk),
      .rst  (rst),
      .run  (run),
      .per  (act_per),
      .duty (act_duty),
      .lvl  (act_lvl),
      .wrap (wrap),
      .out  (pwm_out[i])
    );

    always_comb begin
      ctrl_rb[i]           = '0;
      ctrl_rb[i][BIT_RUN]  = run;
      ctrl_rb[i][BIT_UPD]  = pend;
      ctrl_rb[i][BIT_CONT] = cont;
      ctrl_rb[i][BIT_LVL]  = sh_lvl;
    end
  end

  logic [DW-1:0] rd_val;

  always_comb begin
    rd_val = '0;
    if (in_space) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (ch_sel == CW'(i)) begin
          if (off == STRIDE_LG'(OFF_CTRL))      rd_val = ctrl_rb[i];
          else if (off == STRIDE_LG'(OFF_PER))  rd_val = per_rb[i];
          else if (off == STRIDE_LG'(OFF_DUTY)) rd_val = duty_rb[i];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

  // R2
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !in_space) |=> (bus_rdata == '0));
endmodule

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [5:0]  pwm_out;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwm_bank u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic runs(input int ch, output int hi, output int lo);
    int g = 0;
    hi = 0; lo = 0;
    while (pwm_out[ch] !== 1'b0 && g < 500) begin @(negedge clk); g++; end
    while (pwm_out[ch] !== 1'b1 && g < 1000) begin @(negedge clk); g++; end
    while (pwm_out[ch] === 1'b1 && g < 2000) begin hi++; @(negedge clk); g++; end
    while (pwm_out[ch] === 1'b0 && g < 3000) begin lo++; @(negedge clk); g++; end
  endtask

  task automatic count_high(input int ch, input int n, output int ones);
    ones = 0;
    for (int k = 0; k < n; k++) begin
      if (pwm_out[ch] === 1'b1) ones++;
      @(negedge clk);
    end
  endtask

  function automatic logic [7:0] ad(input int ch, input int off);
    return 8'(ch * 32 + off);
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    check(pwm_out == 6'b0, "R1 outputs", pwm_out, 0);
    for (int ch = 0; ch < 6; ch++) begin
      rd(ad(ch, 0), d);  check(d == 0, "R1 ctrl", d, 0);
      rd(ad(ch, 8), d);  check(d == 0, "R1 period", d, 0);
      rd(ad(ch, 12), d); check(d == 0, "R1 duty", d, 0);
    end
  endtask

  task automatic t_addr_map;
    logic [31:0] d;
    wr(ad(3, 8), 32'h1234_5678);
    wr(ad(3, 12), 32'h0000_A5A5);
    rd(ad(3, 8), d);  check(d == 32'h1234_5678, "R2 period ch3", d, 32'h1234_5678);
    rd(ad(3, 12), d); check(d == 32'h0000_A5A5, "R2 duty ch3", d, 32'hA5A5);
    rd(ad(2, 8), d);  check(d == 0, "R2 ch2 untouched", d, 0);
    rd(ad(3, 4), d);  check(d == 0, "R2 unmapped offset", d, 0);
    wr(8'hC8, 32'hFFFF_FFFF);
    rd(8'hC8, d);     check(d == 0, "R2 beyond space", d, 0);
    rd(8'hB0, d);     check(d == 0, "R2 at space end", d, 0);
    check(pwm_out == 6'b0, "R2 no start", pwm_out, 0);
    wr(ad(3, 8), 0);
    wr(ad(3, 12), 0);
  endtask

  task automatic t_first_phase_high;
    logic [31:0] d; int hi, lo;
    wr(ad(0, 8), 20);
    wr(ad(0, 12), 5);
    wr(ad(0, 0), 32'h124);
    rd(ad(0, 0), d); check(d == 32'h120, "R5 update bit cleared when idle", d, 32'h120);
    wr(ad(0, 0), 32'h121);
    runs(0, hi, lo);
    check(hi == 5, "R5 R6 high run", hi, 5);
    check(lo == 15, "R6 low run", lo, 15);
  endtask

  task automatic t_inverted;
    int hi, lo;
    wr(ad(1, 8), 10);
    wr(ad(1, 12), 4);
    wr(ad(1, 0), 32'h024);
    wr(ad(1, 0), 32'h021);
    runs(1, hi, lo);
    check(hi == 6, "R7 high run", hi, 6);
    check(lo == 4, "R7 low run", lo, 4);
  endtask

  task automatic t_mid_update;
    logic [31:0] d; int hi, lo, t0, g;
    g = 0;
    while (pwm_out[0] !== 1'b1 && g < 500) begin @(negedge clk); g++; end
    while (pwm_out[0] !== 1'b0 && g < 1000) begin @(negedge clk); g++; end
    t0 = cyc;
    wr(ad(0, 8), 6);
    wr(ad(0, 12), 2);
    wr(ad(0, 0), 32'h124);
    rd(ad(0, 0), d); check(d == 32'h125, "R12 pending reads one", d, 32'h125);
    while (pwm_out[0] !== 1'b1 && g < 2000) begin @(negedge clk); g++; end
    check(cyc - t0 == 15, "R4 low run spanning update", cyc - t0, 15);
    rd(ad(0, 0), d); check(d == 32'h121, "R12 pending cleared", d, 32'h121);
    runs(0, hi, lo);
    check(hi == 2 && lo == 4, "R4 new period", {hi, lo}, {32'd2, 32'd4});
  endtask

  task automatic t_shadow_only;
    int hi, lo;
    wr(ad(0, 8), 30);
    wr(ad(0, 12), 11);
    runs(0, hi, lo);
    runs(0, hi, lo);
    check(hi == 2 && lo == 4, "R3 shadow only", {hi, lo}, {32'd2, 32'd4});
  endtask

  task automatic t_sticky_start;
    int hi, lo;
    wr(ad(0, 0), 32'h120);
    runs(0, hi, lo);
    check(hi == 2 && lo == 4, "R11 start stays set", {hi, lo}, {32'd2, 32'd4});
    runs(1, hi, lo);
    check(hi == 6 && lo == 4, "R11 ch1 independent", {hi, lo}, {32'd6, 32'd4});
  endtask

  task automatic t_duty_zero;
    int ones;
    wr(ad(2, 8), 5);
    wr(ad(2, 12), 0);
    wr(ad(2, 0), 32'h124);
    wr(ad(2, 0), 32'h121);
    @(negedge clk);
    count_high(2, 20, ones);
    check(ones == 0, "R8 duty zero static low", ones, 0);
  endtask

  task automatic t_full_duty;
    int ones;
    wr(ad(4, 8), 5);
    wr(ad(4, 12), 9);
    wr(ad(4, 0), 32'h124);
    wr(ad(4, 0), 32'h121);
    @(negedge clk);
    count_high(4, 20, ones);
    check(ones == 20, "R9 duty above period", ones, 20);
  endtask

  task automatic t_zero_period;
    int ones;
    wr(ad(5, 8), 0);
    wr(ad(5, 12), 3);
    wr(ad(5, 0), 32'h024);
    wr(ad(5, 0), 32'h021);
    @(negedge clk);
    count_high(5, 20, ones);
    check(ones == 20, "R10 zero period inactive level", ones, 20);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_addr_map();
    t_first_phase_high();
    t_inverted();
    t_mid_update();
    t_shadow_only();
    t_sticky_start();
    t_duty_zero();
    t_full_duty();
    t_zero_period();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule